// File: doc/BRIEF.md
# Carrier Detect and Preamble Validation Gate

This block sits behind an FSK demodulator on a caller-identity receive path. It takes the recovered bit stream and the demodulator's in-band energy flag, decides whether a carrier is present, and drives three outputs. The first is an active-low carrier-detect. The second is a raw data line that mirrors the demodulator while the carrier is up. The third is a cooked data line that opens only once a proper line-seizure preamble has been recognised.

Timing comes from two strobes that the surrounding logic derives from the system clock. `ms_tick` pulses once per millisecond. `bit_tick` marks the cycle in which `demod_bit` holds a valid bit sample. Carrier assertion requires a short qualification period. Carrier release is delayed by a hold-off, so brief dropouts are ignored. The preamble check needs a long alternating run, then an unbroken mark interval. The cooked line therefore never carries the alternating seizure pattern.

Top module: `cdv_gate`

## Requirements
- R1: After reset, `cd_n`, `raw_out` and `cooked_out` are all high, whatever `demod_bit` is.
- R2: `cd_n` goes low at the 4th `ms_tick` seen while `in_band` has been high without a break; a low `in_band` before that restarts the count from zero.
- R3: Once `cd_n` is low, an absence of `in_band` lasting fewer than 8 `ms_tick` pulses leaves it low, and any return of `in_band` restarts the absence count.
- R4: At the 8th `ms_tick` of a continuous `in_band` absence, `cd_n` returns high.
- R5: `raw_out` equals `demod_bit` while `cd_n` is low and is 1 otherwise.
- R6: `cooked_out` stays 1 during the alternating pattern, and it stays 1 unless at least 30 consecutive alternating bit samples were seen before the mark interval began.
- R7: A mark interval begins with a repeated 1 sample that follows the qualifying alternating run. The cooked line opens on the 120th `ms_tick` after that sample. A 0 sample during the interval cancels it, and a fresh alternating run is then needed.
- R8: Once opened, `cooked_out` equals `demod_bit` until `cd_n` returns high.
- R9: A carrier release returns the validator to idle and drives both data outputs to 1. A new carrier must pass the full preamble again before `cooked_out` opens.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ms_tick | input | 1 | One-cycle strobe every millisecond |
| bit_tick | input | 1 | One-cycle strobe marking a valid bit sample |
| demod_bit | input | 1 | Demodulated data bit (1 = mark) |
| in_band | input | 1 | Demodulator energy-present flag |
| cd_n | output | 1 | Carrier detect, active low |
| raw_out | output | 1 | Demodulator data gated by carrier |
| cooked_out | output | 1 | Demodulator data gated by carrier and preamble validation |

## Verification
A validator stuck open shows up as soon as the demodulator line drops to 0 without a sample strobe. In that case `cooked_out` follows `raw_out` low in the same cycle, when it should stay high. A validator that fails to clear on release shows up in the first cycles of the next carrier, because the cooked line then opens without any preamble. Counting errors in either carrier counter shift the edge of `cd_n` by whole millisecond ticks, which is visible one tick before or after the expected boundary.

// File: rtl/cdv_pkg.sv
package cdv_pkg;
   typedef enum logic [1:0] {
      VS_IDLE  = 2'd0,
      VS_SEIZE = 2'd1,
      VS_MARK  = 2'd2,
      VS_OPEN  = 2'd3
   } vstate_t;
endpackage

// File: rtl/cdv_carrier_filter.sv
module cdv_carrier_filter #(
   parameter int ASSERT_MS = 4,
   parameter int HOLD_MS   = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic ms_tick,
   input  logic in_band,
   output logic carrier_on
);
   localparam int AW = $clog2(ASSERT_MS + 1);
   localparam int HW = $clog2(HOLD_MS + 1);

   generate
      if (ASSERT_MS < 1) begin : g_bad_assert
         $error("ASSERT_MS must be at least 1");
      end
      if (HOLD_MS < 1) begin : g_bad_hold
         $error("HOLD_MS must be at least 1");
      end
   endgenerate

   logic [AW-1:0] qual_cnt;
   logic [HW-1:0] gap_cnt;
   logic          active;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         active   <= 1'b0;
         qual_cnt <= '0;
         gap_cnt  <= '0;
      end else if (!active) begin
         gap_cnt <= '0;
         if (!in_band) begin
            qual_cnt <= '0;
         end else if (ms_tick) begin
            if (qual_cnt == AW'(ASSERT_MS - 1)) begin
               active   <= 1'b1;
               qual_cnt <= '0;
            end else begin
               qual_cnt <= qual_cnt + 1'b1;
            end
         end
      end else begin
         qual_cnt <= '0;
         if (in_band) begin
            gap_cnt <= '0;
         end else if (ms_tick) begin
            if (gap_cnt == HW'(HOLD_MS - 1)) begin
               active  <= 1'b0;
               gap_cnt <= '0;
            end else begin
               gap_cnt <= gap_cnt + 1'b1;
            end
         end
      end
   end

   assign carrier_on = active;

   // R2: carrier can only come up on a millisecond strobe with energy present
   p_rise_on_tick_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(active) |-> ($past(ms_tick) && $past(in_band)));

   // R4: carrier can only drop on a millisecond strobe with energy absent
   p_fall_on_tick_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(active) |-> ($past(ms_tick) && !$past(in_band)));

   // R3: energy present keeps an established carrier up
   p_hold_with_energy_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (active && in_band) |=> active);
endmodule

// File: rtl/cdv_preamble_check.sv
module cdv_preamble_check
   import cdv_pkg::*;
#(
   parameter int MIN_ALT_BITS = 30,
   parameter int MIN_MARK_MS  = 120
) (
   input  logic clk,
   input  logic rst_n,
   input  logic carrier_on,
   input  logic ms_tick,
   input  logic bit_tick,
   input  logic bit_in,
   output logic is_open
);
   localparam int RW = $clog2(MIN_ALT_BITS + 1);
   localparam int MW = $clog2(MIN_MARK_MS + 1);

   generate
      if (MIN_ALT_BITS < 2) begin : g_bad_alt
         $error("MIN_ALT_BITS must be at least 2");
      end
      if (MIN_MARK_MS < 1) begin : g_bad_mark
         $error("MIN_MARK_MS must be at least 1");
      end
   endgenerate

   vstate_t       state;
   logic [RW-1:0] run;
   logic [MW-1:0] mark_cnt;
   logic          prev_bit;

   always_ff @(posedge clk) begin
      if (!rst_n || !carrier_on) begin
         state    <= VS_IDLE;
         run      <= '0;
         mark_cnt <= '0;
         prev_bit <= 1'b0;
      end else begin
         unique case (state)
            VS_IDLE, VS_SEIZE: begin
               state <= VS_SEIZE;
               if (bit_tick) begin
                  prev_bit <= bit_in;
                  if (run == '0) begin
                     run <= RW'(1);
                  end else if (bit_in != prev_bit) begin
                     if (run != RW'(MIN_ALT_BITS)) run <= run + 1'b1;
                  end else if (bit_in && run == RW'(MIN_ALT_BITS)) begin
                     state    <= VS_MARK;
                     mark_cnt <= '0;
                  end else begin
                     run <= RW'(1);
                  end
               end
            end
            VS_MARK: begin
               if (bit_tick && !bit_in) begin
                  state    <= VS_SEIZE;
                  run      <= RW'(1);
                  prev_bit <= 1'b0;
               end else if (ms_tick) begin
                  if (mark_cnt == MW'(MIN_MARK_MS - 1)) state <= VS_OPEN;
                  else mark_cnt <= mark_cnt + 1'b1;
               end
            end
            VS_OPEN: state <= VS_OPEN;
            default: state <= VS_IDLE;
         endcase
      end
   end

   assign is_open = (state == VS_OPEN);

   // R9: losing the carrier always returns the validator to idle
   p_idle_on_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !carrier_on |=> (state == VS_IDLE));

   // R7: opening happens only out of the mark interval on a millisecond strobe
   p_open_from_mark_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(is_open) |-> ($past(state) == VS_MARK && $past(ms_tick)));

   // R6: the mark interval is entered only from a saturated alternating run
   p_mark_needs_run_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (state != VS_MARK) ##1 (state == VS_MARK) |-> ($past(run) == RW'(MIN_ALT_BITS)));
endmodule

// File: rtl/cdv_gate.sv
module cdv_gate #(
   parameter int ASSERT_MS    = 4,
   parameter int HOLD_MS      = 8,
   parameter int MIN_ALT_BITS = 30,
   parameter int MIN_MARK_MS  = 120
) (
   input  logic clk,
   input  logic rst_n,
   input  logic ms_tick,
   input  logic bit_tick,
   input  logic demod_bit,
   input  logic in_band,
   output logic cd_n,
   output logic raw_out,
   output logic cooked_out
);
   logic carrier_on;
   logic val_open;

   cdv_carrier_filter #(
      .ASSERT_MS (ASSERT_MS),
      .HOLD_MS   (HOLD_MS)
   ) u_filter (
      .clk        (clk),
      .rst_n      (rst_n),
      .ms_tick    (ms_tick),
      .in_band    (in_band),
      .carrier_on (carrier_on)
   );

   cdv_preamble_check #(
      .MIN_ALT_BITS (MIN_ALT_BITS),
      .MIN_MARK_MS  (MIN_MARK_MS)
   ) u_check (
      .clk        (clk),
      .rst_n      (rst_n),
      .carrier_on (carrier_on),
      .ms_tick    (ms_tick),
      .bit_tick   (bit_tick),
      .bit_in     (demod_bit),
      .is_open    (val_open)
   );

   assign cd_n       = ~carrier_on;
   assign raw_out    = carrier_on ? demod_bit : 1'b1;
   assign cooked_out = (carrier_on && val_open) ? demod_bit : 1'b1;

   // R6: the cooked line never shows a space the raw line does not show
   p_cooked_subset_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !cooked_out |-> !raw_out);

   // R5: with no carrier, the raw line idles at mark
   p_raw_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
      cd_n |-> raw_out);
endmodule

// File: tb/cdv_gate_bench.sv
`timescale 1ns/1ps
module cdv_gate_bench;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic ms_tick = 1'b0;
   logic bit_tick = 1'b0;
   logic demod_bit = 1'b0;
   logic in_band = 1'b0;
   logic cd_n, raw_out, cooked_out;

   always #2.5 clk = ~clk;

   cdv_gate u_cdv_gate (
      .clk        (clk),
      .rst_n      (rst_n),
      .ms_tick    (ms_tick),
      .bit_tick   (bit_tick),
      .demod_bit  (demod_bit),
      .in_band    (in_band),
      .cd_n       (cd_n),
      .raw_out    (raw_out),
      .cooked_out (cooked_out)
   );

   typedef struct {
      logic  cd;
      logic  raw;
      logic  ck;
      string tag;
   } exp_t;

   exp_t q[$];
   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   // monitor: pops expectations and compares against the ports
   initial begin
      forever begin
         @(negedge clk);
         #1;
         while (q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            checks++;
            if (cd_n !== e.cd || raw_out !== e.raw || cooked_out !== e.ck) begin
               errors++;
               $display("FAIL %s: got cd_n=%b raw=%b cooked=%b, expected cd_n=%b raw=%b cooked=%b",
                        e.tag, cd_n, raw_out, cooked_out, e.cd, e.raw, e.ck);
            end
         end
      end
   end

   task automatic expect_out(input logic cd, input logic raw, input logic ck, input string tag);
      exp_t e;
      @(negedge clk);
      e.cd = cd; e.raw = raw; e.ck = ck; e.tag = tag;
      q.push_back(e);
   endtask

   task automatic tick_ms(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk) ms_tick = 1'b1;
         @(negedge clk) ms_tick = 1'b0;
      end
   endtask

   task automatic send_bit(input logic b);
      @(negedge clk) begin demod_bit = b; bit_tick = 1'b1; end
      @(negedge clk) bit_tick = 1'b0;
   endtask

   task automatic send_alt(input int n);
      for (int i = 0; i < n; i++) send_bit(logic'(i % 2));
   endtask

   task automatic set_line(input logic b);
      @(negedge clk) demod_bit = b;
   endtask

   task automatic finish_run();
      repeat (3) @(negedge clk);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   endtask

   // watchdog
   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: got timeout, expected completion");
         finish_run();
      end
   end

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      // R1 reset state
      expect_out(1, 1, 1, "R1 reset idle");
      set_line(0);
      expect_out(1, 1, 1, "R1 outputs high with line low");

      // R2 qualification, with restart
      in_band = 1'b1;
      tick_ms(3);
      expect_out(1, 1, 1, "R2 three ticks not enough");
      @(negedge clk) in_band = 1'b0;
      @(negedge clk) in_band = 1'b1;
      tick_ms(3);
      expect_out(1, 1, 1, "R2 count restarted by gap");
      tick_ms(1);
      expect_out(0, 0, 1, "R2 fourth tick asserts");

      // R5 raw follows the line
      set_line(1);
      expect_out(0, 1, 1, "R5 raw follows mark");

      // R6 short alternation then long mark: stays closed
      send_alt(20);
      set_line(0);
      expect_out(0, 0, 1, "R6 closed during alternation");
      for (int i = 0; i < 130; i++) begin send_bit(1); tick_ms(1); end
      set_line(0);
      expect_out(0, 0, 1, "R6 short run never opens");

      // R7 mark interrupted by a space
      send_alt(40);
      send_bit(1);
      tick_ms(60);
      send_bit(0);
      for (int i = 0; i < 130; i++) begin send_bit(1); tick_ms(1); end
      set_line(0);
      expect_out(0, 0, 1, "R7 broken mark stays closed");

      // R7 boundary: 119 ticks closed, 120th opens
      send_alt(40);
      send_bit(1);
      tick_ms(119);
      set_line(0);
      expect_out(0, 0, 1, "R7 closed at 119 ms");
      set_line(1);
      tick_ms(1);
      set_line(0);
      expect_out(0, 0, 0, "R7 open at 120 ms");

      // R8 cooked follows the line
      send_bit(1);
      expect_out(0, 1, 1, "R8 cooked follows mark");
      send_bit(0);
      expect_out(0, 0, 0, "R8 cooked follows space");

      // R3 short dropouts tolerated, count restarts
      @(negedge clk) in_band = 1'b0;
      tick_ms(7);
      expect_out(0, 0, 0, "R3 seven ms gap held");
      @(negedge clk) in_band = 1'b1;
      @(negedge clk) in_band = 1'b0;
      tick_ms(7);
      expect_out(0, 0, 0, "R3 gap count restarted");

      // R4 release
      tick_ms(1);
      expect_out(1, 1, 1, "R4 eighth ms releases");
      set_line(1);
      set_line(0);
      expect_out(1, 1, 1, "R5 raw idle after release");

      // R9 new carrier needs full preamble
      @(negedge clk) in_band = 1'b1;
      tick_ms(4);
      expect_out(0, 0, 1, "R9 cooked closed after re-acquire");
      tick_ms(130);
      expect_out(0, 0, 1, "R9 still closed without preamble");

      repeat (4) @(negedge clk);
      done = 1'b1;
      finish_run();
   end
endmodule